// File: doc/BRIEF.md
# Control-Bit Configured Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It takes two two's-complement operands and returns one result of the same width, plus two status flags. There is no opcode. Six independent control bits act in a fixed order. Two condition the first operand, two condition the second operand, one picks between a sum and a bitwise AND, and one inverts the result. Their combinations give eighteen useful functions. Subtraction, increment, decrement and negation come from one shared adder working with bitwise inversion, not from dedicated circuits.

A processor datapath drives the operands from its registers and takes the control bits from instruction fields. It uses the zero and negative flags to decide conditional jumps. The block has no carry-out and no overflow output. The width is a parameter with a default of 16. A second parameter chooses between an explicit ripple-carry adder and a behavioural adder.

Top module: `bitctl_alu`

## Requirements
- R1: When `clr_a` is 1 the first operand is replaced by zero before any inversion. Example: control 101010 in order (clr_a, inv_a, clr_b, inv_b, use_sum, inv_out) yields 0 for any operands.
- R2: When `inv_a` is 1 the (possibly cleared) first operand is bitwise inverted. Example: control 001100 passes `a_in` unchanged and 001101 yields `~a_in`.
- R3: `clr_b` and `inv_b` act on the second operand in the same way as R1 and R2. Example: control 110000 passes `b_in` unchanged and 110001 yields `~b_in`.
- R4: With `use_sum` = 1 the function stage adds the conditioned operands modulo 2^WIDTH. With `use_sum` = 0 it takes their bitwise AND.
- R5: When `inv_out` is 1 the function-stage output is bitwise inverted before it reaches `result`.
- R6: `is_zero` is 1 exactly when every bit of `result` is 0.
- R7: `is_neg` always equals the most significant bit of `result`.
- R8: The eighteen encodings (control order as in R1) give these functions. 101010 gives 0, 111111 gives 1, 111010 gives -1, 001100 gives a, 110000 gives b, 001101 gives ~a and 110001 gives ~b. 001111 gives -a, 110011 gives -b, 011111 gives a+1, 110111 gives b+1, 001110 gives a-1 and 110010 gives b-1. 000010 gives a+b, 010011 gives a-b, 000111 gives b-a, 000000 gives a&b and 010101 gives a|b.
- R9: Addition wraps without any indication. Example: 0x7FFF plus 1 gives 0x8000 with `is_neg` = 1, and 0xFFFF plus 1 gives 0x0000 with `is_zero` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand, two's complement |
| b_in | input | WIDTH | Second operand, two's complement |
| clr_a | input | 1 | Force first operand to zero |
| inv_a | input | 1 | Invert first operand after clearing |
| clr_b | input | 1 | Force second operand to zero |
| inv_b | input | 1 | Invert second operand after clearing |
| use_sum | input | 1 | 1 selects sum, 0 selects bitwise AND |
| inv_out | input | 1 | Invert the function-stage output |
| result | output | WIDTH | Conditioned function result |
| is_zero | output | 1 | High when result is all zeros |
| is_neg | output | 1 | Copy of result sign bit |

## Verification
The checker's assertions are combinational. They assume every input is a known 0 or 1 and that all inputs change together, so no evaluation sees a half-updated control word. The bench meets both assumptions. It drives the control bits and both operands in one statement at the falling clock edge from a single process. It never leaves an input undriven, and it reads the outputs only after the inputs have been stable for a quarter period. The operands include the values most likely to expose sign and carry errors: 0, 1, all ones, the largest positive value and the most negative value. Seeded random pairs are added to these.

// File: rtl/bitctl_alu_pkg.sv
package bitctl_alu_pkg;

   typedef struct packed {
      logic clr_a;
      logic inv_a;
      logic clr_b;
      logic inv_b;
      logic use_sum;
      logic inv_out;
   } alu_ctl_t;

   localparam int unsigned CTL_BITS = 6;

endpackage

// File: rtl/bitctl_operand_cond.sv
module bitctl_operand_cond #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] opnd_i,
   input  logic             clear_i,
   input  logic             invert_i,
   output logic [WIDTH-1:0] opnd_o
);

   logic [WIDTH-1:0] cleared;

   // clear first, invert second: order is behaviour
   always_comb begin
      cleared = clear_i ? '0 : opnd_i;
      opnd_o  = invert_i ? ~cleared : cleared;
   end

endmodule

// File: rtl/bitctl_func_stage.sv
module bitctl_func_stage #(
   parameter int unsigned WIDTH  = 16,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] lhs_i,
   input  logic [WIDTH-1:0] rhs_i,
   input  logic             use_sum_i,
   output logic [WIDTH-1:0] func_o
);

   logic [WIDTH-1:0] sum;
   logic [WIDTH-1:0] conj;

   assign conj = lhs_i & rhs_i;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = lhs_i[i] ^ rhs_i[i] ^ carry[i];
            assign carry[i+1] = (lhs_i[i] & rhs_i[i]) |
                                (carry[i] & (lhs_i[i] ^ rhs_i[i]));
         end
      end else begin : g_behav
         assign sum = lhs_i + rhs_i;
      end
   endgenerate

   assign func_o = use_sum_i ? sum : conj;

endmodule

// File: rtl/bitctl_out_cond.sv
module bitctl_out_cond #(
   parameter int unsigned WIDTH = 16
) (
   input  logic [WIDTH-1:0] func_i,
   input  logic             invert_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             neg_o
);

   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      result_o = invert_i ? ~func_i : func_i;
      zero_o   = ~|result_o;
      neg_o    = result_o[MSB];
   end

endmodule

// File: rtl/bitctl_alu.sv
module bitctl_alu
   import bitctl_alu_pkg::*;
#(
   parameter int unsigned WIDTH  = 16,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             clr_a,
   input  logic             inv_a,
   input  logic             clr_b,
   input  logic             inv_b,
   input  logic             use_sum,
   input  logic             inv_out,
   output logic [WIDTH-1:0] result,
   output logic             is_zero,
   output logic             is_neg
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bitctl_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] a_cond;
   logic [WIDTH-1:0] b_cond;
   logic [WIDTH-1:0] func_val;

   assign ctl = '{clr_a: clr_a, inv_a: inv_a, clr_b: clr_b,
                  inv_b: inv_b, use_sum: use_sum, inv_out: inv_out};

   bitctl_operand_cond #(.WIDTH(WIDTH)) u_cond_a (
      .opnd_i   (a_in),
      .clear_i  (ctl.clr_a),
      .invert_i (ctl.inv_a),
      .opnd_o   (a_cond)
   );

   bitctl_operand_cond #(.WIDTH(WIDTH)) u_cond_b (
      .opnd_i   (b_in),
      .clear_i  (ctl.clr_b),
      .invert_i (ctl.inv_b),
      .opnd_o   (b_cond)
   );

   bitctl_func_stage #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_func (
      .lhs_i     (a_cond),
      .rhs_i     (b_cond),
      .use_sum_i (ctl.use_sum),
      .func_o    (func_val)
   );

   bitctl_out_cond #(.WIDTH(WIDTH)) u_out (
      .func_i   (func_val),
      .invert_i (ctl.inv_out),
      .result_o (result),
      .zero_o   (is_zero),
      .neg_o    (is_neg)
   );

endmodule

// File: rtl/bitctl_alu_chk.sv
module bitctl_alu_chk #(
   parameter int unsigned WIDTH = 16
) (
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic             clr_a,
   input logic             inv_a,
   input logic             clr_b,
   input logic             inv_b,
   input logic             use_sum,
   input logic             inv_out,
   input logic [WIDTH-1:0] result,
   input logic             is_zero,
   input logic             is_neg
);

   logic [5:0] code;
   assign code = {clr_a, inv_a, clr_b, inv_b, use_sum, inv_out};

   always_comb begin
      p_zero_flag_r6: assert (is_zero == (result == '0));
      p_sign_flag_r7: assert (is_neg == result[WIDTH-1]);
      if (code == 6'b101010)
         p_const_zero_r1: assert (result == '0);
      if (code == 6'b001100)
         p_pass_a_r2: assert (result == a_in);
      if (code == 6'b110000)
         p_pass_b_r3: assert (result == b_in);
      if (code == 6'b000010)
         p_add_wrap_r4: assert (result == WIDTH'(a_in + b_in));
      if (code == 6'b111010)
         p_all_ones_r8: assert (result == '1);
   end

endmodule

bind bitctl_alu bitctl_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_bitctl_alu.sv
module sim_bitctl_alu;

   localparam int unsigned W = 16;
   localparam int unsigned NFUNC = 18;
   localparam int unsigned NCORNER = 5;
   localparam int unsigned NRAND = 30;
   localparam int unsigned WATCHDOG = 100000;

   // each entry: {control code (clr_a..inv_out), function id}
   localparam logic [10:0] VEC [NFUNC] = '{
      {6'b101010, 5'd0},  {6'b111111, 5'd1},  {6'b111010, 5'd2},
      {6'b001100, 5'd3},  {6'b110000, 5'd4},  {6'b001101, 5'd5},
      {6'b110001, 5'd6},  {6'b001111, 5'd7},  {6'b110011, 5'd8},
      {6'b011111, 5'd9},  {6'b110111, 5'd10}, {6'b001110, 5'd11},
      {6'b110010, 5'd12}, {6'b000010, 5'd13}, {6'b010011, 5'd14},
      {6'b000111, 5'd15}, {6'b000000, 5'd16}, {6'b010101, 5'd17}
   };

   localparam logic [W-1:0] CORNER [NCORNER] = '{
      16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [W-1:0] a_in, b_in, result;
   logic clr_a, inv_a, clr_b, inv_b, use_sum, inv_out;
   logic is_zero, is_neg;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   bitctl_alu #(.WIDTH(W)) u0 (
      .a_in(a_in), .b_in(b_in),
      .clr_a(clr_a), .inv_a(inv_a), .clr_b(clr_b), .inv_b(inv_b),
      .use_sum(use_sum), .inv_out(inv_out),
      .result(result), .is_zero(is_zero), .is_neg(is_neg)
   );

   function automatic logic [W-1:0] model(input logic [4:0] id,
                                          input logic [W-1:0] x,
                                          input logic [W-1:0] y);
      case (id)
         5'd0:  return '0;
         5'd1:  return W'(1);
         5'd2:  return '1;
         5'd3:  return x;
         5'd4:  return y;
         5'd5:  return ~x;
         5'd6:  return ~y;
         5'd7:  return W'(-x);
         5'd8:  return W'(-y);
         5'd9:  return W'(x + 1);
         5'd10: return W'(y + 1);
         5'd11: return W'(x - 1);
         5'd12: return W'(y - 1);
         5'd13: return W'(x + y);
         5'd14: return W'(x - y);
         5'd15: return W'(y - x);
         5'd16: return x & y;
         default: return x | y;
      endcase
   endfunction

   task automatic apply(input logic [5:0] code,
                        input logic [W-1:0] x, input logic [W-1:0] y);
      @(negedge clk);
      {clr_a, inv_a, clr_b, inv_b, use_sum, inv_out, a_in, b_in} = {code, x, y};
      #5;
   endtask

   task automatic check(input string req, input logic [W-1:0] exp_r);
      logic exp_z;
      logic exp_n;
      exp_z = (exp_r == '0);
      exp_n = exp_r[W-1];
      n_checks++;
      if (result !== exp_r || is_zero !== exp_z || is_neg !== exp_n) begin
         n_fail++;
         $display("FAIL %s: got r=%h z=%b n=%b, expected r=%h z=%b n=%b",
                  req, result, is_zero, is_neg, exp_r, exp_z, exp_n);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd5150));
      {clr_a, inv_a, clr_b, inv_b, use_sum, inv_out, a_in, b_in} = '0;
      repeat (2) @(posedge clk);
      rst = 1'b0;

      // idle state: all-zero inputs give a&b = 0 with zero flag (R6, R8)
      apply(6'b000000, '0, '0);
      check("R6 idle", '0);

      // table walk over corner operand pairs (R8)
      for (int v = 0; v < NFUNC; v++)
         for (int i = 0; i < NCORNER; i++)
            for (int j = 0; j < NCORNER; j++) begin
               apply(VEC[v][10:5], CORNER[i], CORNER[j]);
               check("R8 corner", model(VEC[v][4:0], CORNER[i], CORNER[j]));
            end

      // table walk with random operands (R8, R4)
      for (int v = 0; v < NFUNC; v++)
         for (int k = 0; k < NRAND; k++) begin
            logic [W-1:0] rx, ry;
            rx = W'($urandom);
            ry = W'($urandom);
            apply(VEC[v][10:5], rx, ry);
            check("R8 random", model(VEC[v][4:0], rx, ry));
         end

      // R1: clearing precedes inversion (clr+inv gives all ones on a)
      apply(6'b110000, 16'h1234, 16'h00F0);
      check("R1 clear-then-invert", 16'h00F0 & 16'hFFFF ^ 16'h0000 | 16'h0000);
      apply(6'b110100, 16'h1234, 16'h00F0);
      check("R1 clear-invert a", 16'hFF0F);

      // R2: inversion on a alone under AND with all-ones b
      apply(6'b010000, 16'h0F0F, 16'hFFFF);
      check("R2 invert a", 16'hF0F0);

      // R3: clear b under sum leaves a
      apply(6'b001010, 16'h2468, 16'h5555);
      check("R3 clear b", 16'h2468);
      apply(6'b000100, 16'hFFFF, 16'h0F0F);
      check("R3 invert b", 16'hF0F0);

      // R4: AND versus sum on same operands
      apply(6'b000000, 16'h00FF, 16'h0F0F);
      check("R4 and", 16'h000F);
      apply(6'b000010, 16'h00FF, 16'h0F0F);
      check("R4 sum", 16'h100E);

      // R5: output inversion
      apply(6'b000001, 16'h00FF, 16'h0F0F);
      check("R5 invert out", 16'hFFF0);

      // R7: sign flag from msb
      apply(6'b001100, 16'h8001, 16'h0000);
      check("R7 negative", 16'h8001);

      // R9: wrap cases
      apply(6'b000010, 16'h7FFF, 16'h0001);
      check("R9 wrap to min", 16'h8000);
      apply(6'b000010, 16'hFFFF, 16'h0001);
      check("R9 wrap to zero", 16'h0000);
      apply(6'b011111, 16'h7FFF, 16'h0000);
      check("R9 increment wrap", 16'h8000);
      apply(6'b010011, 16'h8000, 16'h0001);
      check("R9 subtract wrap", 16'h7FFF);

      summary();
   end

endmodule